// File: doc/BRIEF.md
# Single-Wire Bus Master

This block runs the controller side of a single-wire, half-duplex, open-drain serial bus. Software reaches it through a 32-bit synchronous register port with two words. Word 0 holds the configuration, the operation triggers and the status. Word 1 holds an 8-bit data byte. The block never drives the wire high. It only enables a pull-down, and an external pull-up sets the idle level. The wire is read back through a two-flop synchroniser.

Every bus event falls on a whole number of base ticks. A 2-bit prescaler code and an 8-bit divider set the length of one tick. The controller runs three operations:

- **Reset with presence detect.** It drives a reset pulse, then checks whether any device answers.
- **Single-bit slot.** It writes one bit and reads one bit in the same slot.
- **Byte transfer.** It runs eight slots back to back, LSB first. The byte received from the bus replaces the data register in place, one bit per slot.

A one-cycle done pulse marks the end of each operation.

Top module: `owm_ctrl`

## Requirements
- R1: After reset the pull-down is off and the done pulse is low. Word 1 reads zero. Word 0 reads only the line-level bit (bit 29) set, because the idle wire is pulled up.
- R2: In word 0, bit 0 is the enable, bits 2:1 the prescaler code and bits 10:3 the divider. These read back as written. Bits 28:11 always read zero, including the trigger bits. Word 1 returns the data byte in bits 7:0 and zeros above it.
- R3: One base tick lasts P × (divider + 1) clock cycles. P is 2, 4, 8 or 64 for prescaler codes 00, 01, 10 and 11.
- R4: A bit slot pulls the wire low from its start. The wire is released after 1 tick when the bit sent is 1, and after 7 ticks when it is 0. The slot lasts 9 ticks.
- R5: The wire is sampled 2 ticks into each slot. A single-bit operation sends data bit 0 and stores the sampled level into data bit 7, leaving bits 6:0 unchanged. This needs a base tick of at least 4 cycles, to allow for the synchroniser delay.
- R6: A byte operation sends data bits 0 to 7 in eight consecutive slots. Each sampled bit is shifted into bit 7 while the register moves right, so at the end the register holds the received byte, LSB first.
- R7: A reset operation pulls the wire low for 48 ticks. At tick 55 it sets the presence flag (word 0 bit 30) if the wire is low and clears it otherwise. The operation ends at tick 96.
- R8: The done output is high for exactly one cycle, in the cycle in which busy clears, at the end of every completed operation.
- R9: Busy (word 0 bit 31) is set from the cycle after an accepted trigger until the operation ends. Bit 29 returns the synchronised wire level.
- R10: Three kinds of write are ignored: a trigger written while busy, a trigger written while the enable was clear before the write, and a data write made while busy.
- R11: Triggers are bit 11 (reset), bit 12 (single bit) and bit 13 (byte). When several are set in one write, reset wins over byte, and byte wins over single bit.
- R12: Writing word 0 with the enable clear aborts any operation. In the next cycle the wire is released, busy and presence are clear, and no done pulse is raised.
- R13: The pull-down is only ever active while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 control/status, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the word selected in the previous cycle |
| bus_drive_low | output | 1 | Enables the pull-down on the wire |
| bus_in | input | 1 | Wire level, asynchronous |
| op_done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The bench builds the block with its default parameters: an 8-bit data byte, an 8-bit divider, slot points at ticks 1, 2, 7 and 9, and reset points at ticks 48, 55 and 96. At run time it programs base ticks of 4, 8, 24 and 64 cycles, so every prescaler code is used. The 64-cycle base makes a full reset operation last more than six thousand cycles. A behavioural device model answers each slot with chosen bits and a presence pulse. The bench predicts the pull-down and the done pulse for every cycle, and reads the registers back at chosen points. This covers loopback and device-forced zeros, trigger priority, writes ignored while busy or disabled, and an abort in the middle of a reset pulse.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESET,
    ST_SLOT
  } owm_state_t;

  // Shift amount that turns the 2-bit prescaler code into its power of two
  function automatic logic [2:0] presc_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd3;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/owm_tick_gen.sv
module owm_tick_gen
  import owm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [1:0]       presc,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam int CNT_W = DIV_W + 6;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = ((CNT_W'(div) + CNT_W'(1)) << presc_shift(presc)) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (cnt_q == limit)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick = run && !restart && (cnt_q == limit);

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int TCNT_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int T_REL_HI    = 1,
  parameter int T_SAMPLE    = 2,
  parameter int T_REL_LO    = 7,
  parameter int T_SLOT      = 9,
  parameter int T_RST_REL   = 48,
  parameter int T_PRES      = 55,
  parameter int T_RST_END   = 96
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bus_drive_low,
  input  logic        bus_in,
  output logic        op_done
);

  localparam int REG_W     = 32;
  localparam int EN_BIT    = 0;
  localparam int PRSC_LSB  = 1;
  localparam int DIV_LSB   = 3;
  localparam int TRG_RST   = DIV_LSB + DIV_W;
  localparam int TRG_BIT   = TRG_RST + 1;
  localparam int TRG_BYTE  = TRG_RST + 2;
  localparam int LINE_BIT  = REG_W - 3;
  localparam int PRES_BIT  = REG_W - 2;
  localparam int BUSY_BIT  = REG_W - 1;
  localparam int BCNT_W    = $clog2(DATA_W);

  localparam logic [TCNT_W-1:0] TK_REL_HI  = TCNT_W'(T_REL_HI);
  localparam logic [TCNT_W-1:0] TK_SAMPLE  = TCNT_W'(T_SAMPLE);
  localparam logic [TCNT_W-1:0] TK_REL_LO  = TCNT_W'(T_REL_LO);
  localparam logic [TCNT_W-1:0] TK_SLOT    = TCNT_W'(T_SLOT);
  localparam logic [TCNT_W-1:0] TK_RST_REL = TCNT_W'(T_RST_REL);
  localparam logic [TCNT_W-1:0] TK_PRES    = TCNT_W'(T_PRES);
  localparam logic [TCNT_W-1:0] TK_RST_END = TCNT_W'(T_RST_END);
  localparam logic [BCNT_W-1:0] BCNT_LAST  = BCNT_W'(DATA_W - 1);

  // configuration and data
  logic              en_q;
  logic [1:0]        prsc_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] data_q;

  // sequencer state
  owm_state_t        state_q;
  logic              busy_q;
  logic              drive_q;
  logic              done_q;
  logic              pres_q;
  logic              is_byte_q;
  logic              cur_bit_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [TCNT_W-1:0] tcnt_inc;
  logic [BCNT_W-1:0] bcnt_q;

  logic ctrl_wr, data_wr, en_nxt, trig_acc, sel_rst, sel_byte;
  logic tick, line_s;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata[REG_W-1:TRG_BYTE+1];

  assign ctrl_wr  = reg_wr && !reg_addr;
  assign data_wr  = reg_wr && reg_addr;
  assign en_nxt   = ctrl_wr ? reg_wdata[EN_BIT] : en_q;
  assign trig_acc = ctrl_wr && reg_wdata[EN_BIT] && en_q && !busy_q &&
                    (reg_wdata[TRG_BYTE:TRG_RST] != 3'b000);
  assign sel_rst  = reg_wdata[TRG_RST];
  assign sel_byte = reg_wdata[TRG_BYTE];
  assign tcnt_inc = tcnt_q + TCNT_W'(1);

  owm_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_in),
    .q   (line_s)
  );

  owm_tick_gen #(
    .DIV_W (DIV_W)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (busy_q),
    .restart (trig_acc),
    .presc   (prsc_q),
    .div     (div_q),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      prsc_q    <= '0;
      div_q     <= '0;
      data_q    <= '0;
      state_q   <= ST_IDLE;
      busy_q    <= 1'b0;
      drive_q   <= 1'b0;
      done_q    <= 1'b0;
      pres_q    <= 1'b0;
      is_byte_q <= 1'b0;
      cur_bit_q <= 1'b0;
      tcnt_q    <= '0;
      bcnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (ctrl_wr) begin
        en_q   <= reg_wdata[EN_BIT];
        prsc_q <= reg_wdata[PRSC_LSB +: 2];
        div_q  <= reg_wdata[DIV_LSB +: DIV_W];
      end
      if (data_wr && !busy_q) data_q <= reg_wdata[DATA_W-1:0];

      if (!en_nxt) begin
        state_q <= ST_IDLE;
        busy_q  <= 1'b0;
        drive_q <= 1'b0;
        pres_q  <= 1'b0;
        tcnt_q  <= '0;
        bcnt_q  <= '0;
      end else if (trig_acc) begin
        busy_q  <= 1'b1;
        drive_q <= 1'b1;
        tcnt_q  <= '0;
        bcnt_q  <= '0;
        if (sel_rst) begin
          state_q <= ST_RESET;
        end else begin
          state_q   <= ST_SLOT;
          is_byte_q <= sel_byte;
          cur_bit_q <= data_q[0];
        end
      end else if (tick) begin
        tcnt_q <= tcnt_inc;
        case (state_q)
          ST_RESET: begin
            if (tcnt_inc == TK_RST_REL) drive_q <= 1'b0;
            if (tcnt_inc == TK_PRES)    pres_q  <= !line_s;
            if (tcnt_inc == TK_RST_END) begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end
          end
          ST_SLOT: begin
            if (tcnt_inc == TK_REL_HI && cur_bit_q) drive_q <= 1'b0;
            if (tcnt_inc == TK_REL_LO)              drive_q <= 1'b0;
            if (tcnt_inc == TK_SAMPLE) begin
              if (is_byte_q) data_q <= {line_s, data_q[DATA_W-1:1]};
              else           data_q <= {line_s, data_q[DATA_W-2:0]};
            end
            if (tcnt_inc == TK_SLOT) begin
              if (is_byte_q && bcnt_q != BCNT_LAST) begin
                bcnt_q    <= bcnt_q + BCNT_W'(1);
                tcnt_q    <= '0;
                drive_q   <= 1'b1;
                cur_bit_q <= data_q[0];
              end else begin
                state_q <= ST_IDLE;
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // registered read port
  logic [REG_W-1:0] ctrl_view;

  always_comb begin
    ctrl_view                       = '0;
    ctrl_view[EN_BIT]               = en_q;
    ctrl_view[PRSC_LSB +: 2]        = prsc_q;
    ctrl_view[DIV_LSB +: DIV_W]     = div_q;
    ctrl_view[LINE_BIT]             = line_s;
    ctrl_view[PRES_BIT]             = pres_q;
    ctrl_view[BUSY_BIT]             = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata <= '0;
    else if (reg_addr) reg_rdata <= {{(REG_W-DATA_W){1'b0}}, data_q};
    else               reg_rdata <= ctrl_view;
  end

  assign bus_drive_low = drive_q;
  assign op_done       = done_q;

endmodule

// File: rtl/owm_ctrl_chk.sv
module owm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic reg_wr,
  input logic reg_addr,
  input logic wen_bit,
  input logic bus_drive_low,
  input logic op_done,
  input logic busy,
  input logic en
);

  // R13
  drive_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_drive_low |-> busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (!busy && $past(busy)));

  // R12
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr && !wen_bit) |=> (!bus_drive_low && !busy && !op_done));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && !reg_addr && en));

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!bus_drive_low && !busy));

endmodule

bind owm_ctrl owm_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .wen_bit       (reg_wdata[0]),
  .bus_drive_low (bus_drive_low),
  .op_done       (op_done),
  .busy          (busy_q),
  .en            (en_q)
);

// File: tb/owm_ctrl_tb.sv
module owm_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_drive_low;
  logic        op_done;
  logic        bus_in;
  logic        dev_low = 1'b0;

  always #5 clk = ~clk;

  assign bus_in = ~(bus_drive_low | dev_low);

  owm_ctrl u_dut (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .bus_drive_low (bus_drive_low),
    .bus_in        (bus_in),
    .op_done       (op_done)
  );

  integer checks = 0;
  integer fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model state
  bit        m_en, m_busy, m_pres, m_done, busy_old, acc;
  int        m_op, m_j, m_total, m_T, s_b, pos_b, s_n, pos_n;
  logic [7:0] m_data, m_tx;
  logic [7:0] dev_resp = 8'hFF;
  bit        dev_present = 1'b1;
  logic      exp_drive;

  function automatic int presc(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 64;
    endcase
  endfunction

  // tr: bit0 reset trigger, bit1 single-bit trigger, bit2 byte trigger
  function automatic logic [31:0] cfg(input logic en, input logic [1:0] ps,
                                      input logic [7:0] dv, input logic [2:0] tr);
    return {18'd0, tr, dv, ps, en};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_busy = 0; m_pres = 0; m_done = 0; m_op = 0;
      m_j = 0; m_total = 0; m_T = 1; m_data = '0; m_tx = '0;
      dev_low <= 1'b0;
    end else begin
      busy_old = m_busy;
      acc = reg_wr && !reg_addr && m_en && !m_busy && reg_wdata[0] &&
            (reg_wdata[13:11] != 3'b000);
      m_done = 0;
      if (reg_wr && !reg_addr && !reg_wdata[0]) begin
        m_busy = 0; m_pres = 0; m_op = 0;
      end else if (m_busy) begin
        m_j = m_j + 1;
        if (m_j == m_total) begin
          m_busy = 0;
          m_done = 1;
          case (m_op)
            1:       m_pres = dev_present;
            2:       m_data[7] = m_tx[0] & dev_resp[0];
            default: m_data = m_tx & dev_resp;
          endcase
        end
      end
      if (reg_wr && reg_addr && !busy_old) m_data = reg_wdata[7:0];
      if (reg_wr && !reg_addr) m_en = reg_wdata[0];
      if (acc) begin
        m_T = presc(reg_wdata[2:1]) * (int'(reg_wdata[10:3]) + 1);
        m_tx = m_data;
        m_j = 0;
        m_busy = 1;
        if (reg_wdata[11])      begin m_op = 1; m_total = 96 * m_T; end
        else if (reg_wdata[13]) begin m_op = 3; m_total = 72 * m_T; end
        else                    begin m_op = 2; m_total = 9 * m_T;  end
      end
      if (m_busy && m_op == 1) begin
        dev_low <= dev_present && (m_j >= 50 * m_T) && (m_j < 80 * m_T);
      end else if (m_busy) begin
        s_b = m_j / (9 * m_T);
        pos_b = m_j % (9 * m_T);
        dev_low <= !dev_resp[s_b] && (pos_b < 4 * m_T);
      end else begin
        dev_low <= 1'b0;
      end
    end
  end

  // per-cycle comparison of the pin and the done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (m_busy && m_op == 1) begin
        exp_drive = (m_j < 48 * m_T);
        chk("R7 drive", {31'd0, bus_drive_low}, {31'd0, exp_drive});
      end else if (m_busy) begin
        s_n = m_j / (9 * m_T);
        pos_n = m_j % (9 * m_T);
        exp_drive = (pos_n < (m_tx[s_n] ? 1 : 7) * m_T);
        chk("R4 drive", {31'd0, bus_drive_low}, {31'd0, exp_drive});
      end else begin
        chk("R13 idle drive", {31'd0, bus_drive_low}, 32'd0);
      end
      chk("R8 done", {31'd0, op_done}, {31'd0, m_done});
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 32'h2000_0000);
    rd(1'b1, v); chk("R1 data", v, 32'h0000_0000);

    // R2 field readback, triggers while disabled ignored (R10)
    wr(1'b0, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R2 ctrl", v, 32'h2000_07FE);
    wr(1'b1, 32'hFFFF_FF5A);
    rd(1'b1, v); chk("R2 data", v, 32'h0000_005A);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b001));
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R10 trig disabled", v, 32'h2000_0009);

    // R7/R9 reset with presence, base 4
    dev_present = 1'b1;
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b001));
    repeat (6) @(negedge clk);
    rd(1'b0, v); chk("R9 busy", v, 32'h8000_0009);
    wait_idle();
    rd(1'b0, v); chk("R7 presence", v, 32'h6000_0009);

    // R3/R7 no presence, base 8
    dev_present = 1'b0;
    wr(1'b0, cfg(1'b1, 2'b01, 8'd1, 3'b001));
    wait_idle();
    rd(1'b0, v); chk("R7 absent", v, 32'h2000_000B);

    // R5 single-bit slots, base 4
    dev_resp = 8'hFF;
    wr(1'b1, 32'h01);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b010));
    wait_idle();
    rd(1'b1, v); chk("R5 read one", v, 32'h81);
    dev_resp = 8'hFE;
    wr(1'b1, 32'h7F);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b010));
    wait_idle();
    rd(1'b1, v); chk("R5 device zero", v, 32'h7F);
    dev_resp = 8'hFF;
    wr(1'b1, 32'h80);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b010));
    wait_idle();
    rd(1'b1, v); chk("R4 write zero", v, 32'h00);

    // R6 byte transfers
    dev_resp = 8'h3C;
    wr(1'b1, 32'hFF);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b100));
    wait_idle();
    rd(1'b1, v); chk("R6 read byte", v, 32'h3C);
    dev_resp = 8'hFF;
    wr(1'b1, 32'h5A);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b100));
    wait_idle();
    rd(1'b1, v); chk("R6 loopback", v, 32'h5A);
    dev_resp = 8'hF0;
    wr(1'b1, 32'hC3);
    wr(1'b0, cfg(1'b1, 2'b10, 8'd2, 3'b100));
    wait_idle();
    rd(1'b1, v); chk("R6 base 24", v, 32'hC0);

    // R11 priority
    dev_present = 1'b1;
    dev_resp = 8'hFF;
    wr(1'b1, 32'h0F);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b111));
    wait_idle();
    rd(1'b1, v); chk("R11 reset wins data", v, 32'h0F);
    rd(1'b0, v); chk("R11 reset wins pres", v, 32'h6000_0009);
    dev_resp = 8'h33;
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b110));
    wait_idle();
    rd(1'b1, v); chk("R11 byte wins", v, 32'h03);

    // R10 writes while busy ignored
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b001));
    repeat (10) @(negedge clk);
    wr(1'b0, cfg(1'b1, 2'b00, 8'd1, 3'b100));
    wr(1'b1, 32'hAA);
    wait_idle();
    rd(1'b1, v); chk("R10 busy writes", v, 32'h03);

    // R3 prescaler code 11, base 64
    wr(1'b0, cfg(1'b1, 2'b11, 8'd0, 3'b001));
    wait_idle();
    rd(1'b0, v); chk("R3 base 64", v, 32'h6000_0007);

    // R12 abort
    wr(1'b0, cfg(1'b1, 2'b11, 8'd0, 3'b001));
    repeat (100) @(negedge clk);
    wr(1'b0, cfg(1'b0, 2'b11, 8'd0, 3'b000));
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R12 abort", v, 32'h2000_0006);
    repeat (20) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule